// File: doc/BRIEF.md
# Translation Context Selector

This block sits at the front of an address translation pipeline. For every access it decides whether translation is skipped entirely (real mode) or which partition identifier and process identifier qualify the effective address before a table walk. In real mode it produces the real address directly. A real-mode offset is merged in unless the top effective-address bit is set. Otherwise it picks the identifiers from the top two effective-address bits, called the quadrant, with one rule set in hypervisor state and another in guest state. A guest quadrant that has no meaning raises a segment fault, which is reported as an instruction fault or a data fault.

Requests arrive with a valid/ready handshake. The block samples the access, the machine-state bits and the identifier and offset registers on acceptance. One cycle later it presents a registered response. That response is held while the consumer is not ready.

Top module: `tcs_selector`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: Real mode (`rsp_bypass`=1) applies only when `hv_state`=1 and either the access is a fetch (`acc_type`=2) with `instr_reloc`=0, or it is a read (`acc_type`=0) or write (`acc_type`=1) with `data_reloc`=0. Outside hypervisor state, relocation bits have no effect and the quadrant rules apply.
- R3: In real mode, `rsp_raddr` is the effective address with its top 4 bits cleared, and the identifier outputs are 0.
- R4: In real mode, if effective-address bit 63 is 0, `rm_offset` is ORed into `rsp_raddr`. If bit 63 is 1, no offset is added.
- R5: In hypervisor state outside real mode, the quadrant `ea[63:62]` selects the identifiers as follows. Quadrant 0 gives LPID=0 and PID=`pid_reg`. Quadrant 1 gives LPID=`lpid_reg` and PID=`pid_reg`. Quadrant 2 gives LPID=`lpid_reg` and PID=0. Quadrant 3 gives both as 0.
- R6: In guest state, quadrant 0 gives LPID=`lpid_reg` and PID=`pid_reg`, and quadrant 3 gives LPID=`lpid_reg` and PID=0.
- R7: In guest state, quadrants 1 and 2 set `rsp_seg_fault`=1 with zero identifiers. For a fetch, `rsp_fault_instr`=1 and `rsp_fault_addr`=0. For a read or write, `rsp_fault_instr`=0 and `rsp_fault_addr`=effective address.
- R8: Access type 3 sets `rsp_bad_type`=1 with bypass, fault, addresses and identifiers all 0.
- R9: A request accepted at one rising edge gives `rsp_valid`=1 with its result after that edge. A cycle with no request accepted clears `rsp_valid`.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_ea | input | 64 | Effective address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| hv_state | input | 1 | Hypervisor state bit |
| instr_reloc | input | 1 | Instruction relocation enable |
| data_reloc | input | 1 | Data relocation enable |
| pid_reg | input | 20 | Process identifier register |
| lpid_reg | input | 12 | Partition identifier register |
| rm_offset | input | 64 | Hypervisor real-mode offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_bypass | output | 1 | Real mode, translation skipped |
| rsp_raddr | output | 64 | Real address in real mode |
| rsp_lpid | output | 12 | Selected partition identifier |
| rsp_pid | output | 20 | Selected process identifier |
| rsp_seg_fault | output | 1 | Segment fault |
| rsp_fault_instr | output | 1 | Fault is on a fetch |
| rsp_fault_addr | output | 64 | Faulting address for data faults |
| rsp_bad_type | output | 1 | Access type 3 seen |

## Verification
The bench builds the block with its default widths. These are a 64-bit effective address, 20-bit process identifiers and 12-bit partition identifiers. This width keeps bit 63 and the quadrant field at their true positions, so the offset-merge decision and all four quadrants can be reached directly. The register values are distinct nonzero patterns, so a swapped or dropped identifier is visible in every quadrant. The offset is placed in bits the clearing mask keeps, so its presence or absence shows in the real address.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;
endpackage

// File: rtl/tcs_realmode.sv
module tcs_realmode #(
  parameter int EA_W     = 64,
  parameter int CLR_BITS = 4
) (
  input  logic            hv,
  input  logic            ir,
  input  logic            dr,
  input  logic [1:0]      acc,
  input  logic [EA_W-1:0] ea,
  input  logic [EA_W-1:0] offset,
  output logic            is_real,
  output logic [EA_W-1:0] raddr
);
  import tcs_pkg::*;
  localparam int KEEP_W = EA_W - CLR_BITS;
  localparam logic [EA_W-1:0] KEEP_MASK = {{CLR_BITS{1'b0}}, {KEEP_W{1'b1}}};

  logic is_fetch, is_data;

  always_comb begin
    is_fetch = (acc == ACC_FETCH);
    is_data  = (acc == ACC_READ) || (acc == ACC_WRITE);
    is_real  = hv && ((is_fetch && !ir) || (is_data && !dr));
    raddr    = ea & KEEP_MASK;
    if (!ea[EA_W-1]) raddr = raddr | offset;
  end
endmodule

// File: rtl/tcs_quadrant.sv
module tcs_quadrant #(
  parameter int EA_W   = 64,
  parameter int PID_W  = 20,
  parameter int LPID_W = 12
) (
  input  logic              hv,
  input  logic [1:0]        acc,
  input  logic [EA_W-1:0]   ea,
  input  logic [PID_W-1:0]  pid_in,
  input  logic [LPID_W-1:0] lpid_in,
  output logic [PID_W-1:0]  pid_sel,
  output logic [LPID_W-1:0] lpid_sel,
  output logic              fault,
  output logic              fault_instr,
  output logic [EA_W-1:0]   fault_addr
);
  import tcs_pkg::*;
  logic [1:0] quad;

  always_comb begin
    quad        = ea[EA_W-1 -: 2];
    pid_sel     = '0;
    lpid_sel    = '0;
    fault       = 1'b0;
    fault_instr = 1'b0;
    fault_addr  = '0;
    if (hv) begin
      unique case (quad)
        2'd0: pid_sel = pid_in;
        2'd1: begin pid_sel = pid_in; lpid_sel = lpid_in; end
        2'd2: lpid_sel = lpid_in;
        default: ;
      endcase
    end else begin
      unique case (quad)
        2'd0: begin pid_sel = pid_in; lpid_sel = lpid_in; end
        2'd3: lpid_sel = lpid_in;
        default: begin
          fault = 1'b1;
          if (acc == ACC_FETCH) fault_instr = 1'b1;
          else fault_addr = ea;
        end
      endcase
    end
  end

  always_comb begin
    if (fault) assert (!hv && ((pid_sel == '0) && (lpid_sel == '0)))  // R7
      else $error("AST_FAULT_ONLY_GUEST");
  end
endmodule

// File: rtl/tcs_selector.sv
module tcs_selector #(
  parameter int EA_W     = 64,
  parameter int PID_W    = 20,
  parameter int LPID_W   = 12,
  parameter int CLR_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        acc_type,
  input  logic              hv_state,
  input  logic              instr_reloc,
  input  logic              data_reloc,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [EA_W-1:0]   rm_offset,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_bypass,
  output logic [EA_W-1:0]   rsp_raddr,
  output logic [LPID_W-1:0] rsp_lpid,
  output logic [PID_W-1:0]  rsp_pid,
  output logic              rsp_seg_fault,
  output logic              rsp_fault_instr,
  output logic [EA_W-1:0]   rsp_fault_addr,
  output logic              rsp_bad_type
);
  import tcs_pkg::*;

  logic              rm_real;
  logic [EA_W-1:0]   rm_raddr;
  logic [PID_W-1:0]  q_pid;
  logic [LPID_W-1:0] q_lpid;
  logic              q_fault, q_finstr;
  logic [EA_W-1:0]   q_faddr;
  logic              bad, take;

  tcs_realmode #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) rm_i (
    .hv(hv_state), .ir(instr_reloc), .dr(data_reloc), .acc(acc_type),
    .ea(req_ea), .offset(rm_offset), .is_real(rm_real), .raddr(rm_raddr)
  );

  tcs_quadrant #(.EA_W(EA_W), .PID_W(PID_W), .LPID_W(LPID_W)) qd_i (
    .hv(hv_state), .acc(acc_type), .ea(req_ea), .pid_in(pid_reg),
    .lpid_in(lpid_reg), .pid_sel(q_pid), .lpid_sel(q_lpid), .fault(q_fault),
    .fault_instr(q_finstr), .fault_addr(q_faddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign bad       = (acc_type == ACC_BAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_bypass      <= 1'b0;
      rsp_raddr       <= '0;
      rsp_lpid        <= '0;
      rsp_pid         <= '0;
      rsp_seg_fault   <= 1'b0;
      rsp_fault_instr <= 1'b0;
      rsp_fault_addr  <= '0;
      rsp_bad_type    <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_bad_type    <= bad;
        rsp_bypass      <= !bad && rm_real;
        rsp_raddr       <= (!bad && rm_real) ? rm_raddr : '0;
        rsp_seg_fault   <= !bad && !rm_real && q_fault;
        rsp_fault_instr <= !bad && !rm_real && q_finstr;
        rsp_fault_addr  <= (!bad && !rm_real) ? q_faddr : '0;
        rsp_lpid        <= (!bad && !rm_real) ? q_lpid : '0;
        rsp_pid         <= (!bad && !rm_real) ? q_pid : '0;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot0({rsp_bypass, rsp_seg_fault, rsp_bad_type}))
    else $error("AST_ONE_OUTCOME"); // R8
  AST_BYPASS_NO_IDS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_bypass) |-> (rsp_lpid == '0 && rsp_pid == '0))
    else $error("AST_BYPASS_NO_IDS"); // R3
  AST_FETCH_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_seg_fault && rsp_fault_instr) |-> (rsp_fault_addr == '0))
    else $error("AST_FETCH_FAULT_ADDR"); // R7
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid)
    else $error("AST_ACCEPT_LATENCY"); // R9
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_raddr) &&
      $stable(rsp_lpid) && $stable(rsp_pid) && $stable(rsp_bypass) &&
      $stable(rsp_seg_fault) && $stable(rsp_fault_addr)))
    else $error("AST_HOLD_STALL"); // R10
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready)
    else $error("AST_STALL_NOT_READY"); // R10
endmodule

// File: tb/tcs_selector_tb_top.sv
module tcs_selector_tb_top;
  localparam int NV = 15;
  localparam logic [19:0] PIDV  = 20'hABCDE;
  localparam logic [11:0] LPIDV = 12'h5A3;
  localparam logic [63:0] OFFV  = 64'h0000_0001_0000_0000;
  // {hv, ir, dr, acc[1:0], ea[63:0]}
  localparam logic [68:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,2'd2,64'h7234_5678_9ABC_DEF0},
    {1'b1,1'b1,1'b0,2'd0,64'hF000_0000_0000_1234},
    {1'b1,1'b1,1'b0,2'd1,64'h3FFF_0000_0000_0008},
    {1'b1,1'b0,1'b1,2'd0,64'h4000_0000_0000_0010},
    {1'b1,1'b1,1'b1,2'd0,64'h0000_0000_0000_1000},
    {1'b1,1'b1,1'b1,2'd1,64'h4000_0000_0000_2000},
    {1'b1,1'b1,1'b1,2'd0,64'h8000_0000_0000_3000},
    {1'b1,1'b1,1'b1,2'd1,64'hC000_0000_0000_4000},
    {1'b1,1'b1,1'b1,2'd2,64'h8000_0000_0000_5000},
    {1'b0,1'b1,1'b1,2'd0,64'h0000_0000_0000_6000},
    {1'b0,1'b1,1'b1,2'd2,64'hC000_0000_0000_7000},
    {1'b0,1'b1,1'b1,2'd2,64'h4000_0000_0000_8000},
    {1'b0,1'b1,1'b1,2'd1,64'h8123_0000_0000_9000},
    {1'b0,1'b0,1'b0,2'd0,64'h0000_0000_0000_A000},
    {1'b1,1'b0,1'b0,2'd3,64'h1234_0000_0000_B000}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, rsp_ready = 1;
  logic req_ready;
  logic [63:0] req_ea = '0;
  logic [1:0] acc_type = '0;
  logic hv_state = 0, instr_reloc = 0, data_reloc = 0;
  logic rsp_valid, rsp_bypass, rsp_seg_fault, rsp_fault_instr, rsp_bad_type;
  logic [63:0] rsp_raddr, rsp_fault_addr;
  logic [11:0] rsp_lpid;
  logic [19:0] rsp_pid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tcs_selector dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .acc_type(acc_type), .hv_state(hv_state),
    .instr_reloc(instr_reloc), .data_reloc(data_reloc), .pid_reg(PIDV),
    .lpid_reg(LPIDV), .rm_offset(OFFV), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_bypass(rsp_bypass), .rsp_raddr(rsp_raddr),
    .rsp_lpid(rsp_lpid), .rsp_pid(rsp_pid), .rsp_seg_fault(rsp_seg_fault),
    .rsp_fault_instr(rsp_fault_instr), .rsp_fault_addr(rsp_fault_addr),
    .rsp_bad_type(rsp_bad_type)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected response packed as {bad, byp, flt, finstr, lpid12, pid20, raddr64, faddr64}
  function automatic logic [163:0] model(input logic [68:0] v);
    logic hv, ir, dr; logic [1:0] a, q; logic [63:0] ea;
    logic bad, byp, flt, fi; logic [11:0] l; logic [19:0] p; logic [63:0] ra, fa;
    {hv, ir, dr, a, ea} = v;
    q = ea[63:62];
    bad = (a == 2'd3); byp = 0; flt = 0; fi = 0; l = 0; p = 0; ra = 0; fa = 0;
    if (!bad) begin
      if (hv && ((a == 2'd2 && !ir) || (a != 2'd2 && !dr))) begin
        byp = 1;
        ra = {4'h0, ea[59:0]} | (ea[63] ? 64'h0 : OFFV);
      end else if (hv) begin
        if (q == 2'd0) p = PIDV;
        if (q == 2'd1) begin p = PIDV; l = LPIDV; end
        if (q == 2'd2) l = LPIDV;
      end else begin
        if (q == 2'd0) begin p = PIDV; l = LPIDV; end
        else if (q == 2'd3) l = LPIDV;
        else begin flt = 1; fi = (a == 2'd2); fa = fi ? 64'h0 : ea; end
      end
    end
    return {bad, byp, flt, fi, l, p, ra, fa};
  endfunction

  task automatic drive(input logic [68:0] v);
    {hv_state, instr_reloc, data_reloc, acc_type, req_ea} = v;
    req_valid = 1;
  endtask

  task automatic check_rsp(input string tag, input logic [68:0] v);
    logic [163:0] e;
    e = model(v);
    chk({tag, " valid R9"}, 64'(rsp_valid), 64'd1);
    chk({tag, " bad R8"}, 64'(rsp_bad_type), 64'(e[163]));
    chk({tag, " bypass R2"}, 64'(rsp_bypass), 64'(e[162]));
    chk({tag, " fault R7"}, 64'(rsp_seg_fault), 64'(e[161]));
    chk({tag, " finstr R7"}, 64'(rsp_fault_instr), 64'(e[160]));
    chk({tag, " lpid R5 R6"}, 64'(rsp_lpid), 64'(e[159:148]));
    chk({tag, " pid R5 R6"}, 64'(rsp_pid), 64'(e[147:128]));
    chk({tag, " raddr R3 R4"}, rsp_raddr, e[127:64]);
    chk({tag, " faddr R7"}, rsp_fault_addr, e[63:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset rsp_valid R1", 64'(rsp_valid), 64'd0);
    chk("reset req_ready R1", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      req_valid = 0;
      check_rsp($sformatf("vec%0d", i), VEC[i]);
    end

    @(negedge clk);
    chk("idle clears valid R9", 64'(rsp_valid), 64'd0);

    // Directed: offset merge exact values, R4
    chk("R4 model offset present", model(VEC[0])[127:64], 64'h0234_5679_9ABC_DEF0);
    chk("R4 model offset absent", model(VEC[1])[127:64], 64'h0000_0000_0000_1234);

    // Backpressure R10
    rsp_ready = 0;
    drive(VEC[5]);
    @(negedge clk);
    drive(VEC[12]);
    chk("stall req_ready R10", 64'(req_ready), 64'd0);
    check_rsp("stall first", VEC[5]);
    @(negedge clk);
    check_rsp("stall hold R10", VEC[5]);
    chk("stall still not ready R10", 64'(req_ready), 64'd0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check_rsp("after stall", VEC[12]);

    // Back-to-back R9
    drive(VEC[10]);
    @(negedge clk);
    drive(VEC[6]);
    check_rsp("b2b first", VEC[10]);
    @(negedge clk);
    req_valid = 0;
    check_rsp("b2b second", VEC[6]);

    // Reset mid-response R1
    drive(VEC[3]);
    @(negedge clk);
    req_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("reset clears R1", 64'(rsp_valid), 64'd0);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule